// File: doc/BRIEF.md
# Socket DMA Transfer Port Controller

This block is the slave side of a data port that a host processor drives through a small register window. Each of several buffer sockets owns a status bit that the buffer side sets with a one-cycle fill pulse. A socket mask and an interrupt mask turn those bits into an interrupt. The host picks a socket and a direction and arms a transfer with an enable bit. A few cycles later the block reports the buffer size in bytes and opens the data window. It then moves 32-bit words in whole bursts of four.

Ingress words are those the host writes. Egress words are those the host reads. Both go to or come from a small internal word buffer, which stands in for real buffer memory. Words past the reported size are padding. Padding writes are dropped and padding reads return zero. A data access outside the window is ignored, and it latches a sticky error that aborts the transfer. At the end of the last burst the block tears the transfer down after a short fixed delay.

Top module: `sockdma_port`

## Requirements
- R1: After reset every register reads 0, `intr` is 0 and `dat_rdata` is 0.
- R2: A pulse on `sock_fill[i]` sets status bit i (address 0). Event bit 0 (address 3) is the OR of status ANDed with the socket mask (address 1). The event bits are: 0 socket, 1 ready, 2 watermark, 3 error. `intr` is the OR of the event bits ANDed with the interrupt mask (address 2, bits 3:0).
- R3: Writing address 4 with bit 9 set arms a transfer while idle and error-free. Bits 3:0 give the socket and bit 8 the direction (1 = egress/host reads). Exactly 3 cycles after that write, enable (bit 9), size-valid (bit 11) and ready (event bit 1) read 1. Address 5 then reads the byte size from `buf_bytes`, clamped to 64. While size-valid is 0, address 5 reads 0.
- R4: The long-transfer bit (bit 10) written at arming reads back unchanged and does not change the word count.
- R5: A transfer moves ceil(max(words,1)/4)*4 words, where words = ceil(size/4). Enable and ready stay 1 until the last of those words has moved.
- R6: Ingress word i is stored only when 4*i < size. Egress word i returns the stored word i when 4*i < size, and 0 otherwise.
- R7: The watermark bit is 1 while ready, until 2 cycles after word (total-4+2) has moved, that is, word 2 of the final burst.
- R8: Two cycles after the last word, enable, size-valid, ready and the socket's status bit return to 0. A data access after the last word counts as out of window.
- R9: A write while the window is not open for writes, or a read while it is not open for reads, has no effect. Such a read returns 0. Either access sets event bit 3 and aborts any transfer on the next cycle.
- R10: The error bit clears only when the host writes 1 to event bit 3. An arming write made while the error bit is set is refused.
- R11: An arming write during an armed or running transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sock_fill | input | NSOCK | One-cycle pulses marking a socket ready |
| buf_bytes | input | SZW | Buffer or data size in bytes, captured at arming |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dat_wr | input | 1 | Data write strobe (ingress) |
| dat_rd | input | 1 | Data read strobe (egress) |
| dat_wdata | input | DW | Ingress word |
| dat_rdata | output | DW | Egress word, valid while `dat_rd` is high |
| intr | output | 1 | Interrupt request |

## Verification
A word counter that is off by one moves the teardown edge. The enable bit would then fall a cycle early or late after the last word, or a padding read would return stale data instead of zero. Either fault is visible at the ports within one burst. A phase machine stuck in the armed or teardown state shows up as enable failing to rise at the third cycle, or failing to fall by the second cycle after the last word. A lost error latch shows up at once, as a zero error bit and a live interrupt mask with no request. Random round trips of ingress followed by egress compare every read word against a bench-side copy of the buffer, so a misdirected store shows up on the next egress pass.

// File: rtl/sockdma_port.sv
`timescale 1ns/1ps
module sockdma_port #(
  parameter int NSOCK    = 4,
  parameter int DW       = 32,
  parameter int SZW      = 8,
  parameter int BURST    = 4,
  parameter int MEMW     = 16,
  parameter int ACT_LAT  = 3,
  parameter int TEAR_LAT = 2,
  parameter int WMARK    = 2,
  parameter int WM_LAG   = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSOCK-1:0] sock_fill,
  input  logic [SZW-1:0]   buf_bytes,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [DW-1:0]    dat_wdata,
  output logic [DW-1:0]    dat_rdata,
  output logic             intr
);
  localparam int SKW = (NSOCK > 1) ? $clog2(NSOCK) : 1;
  localparam int MIW = $clog2(MEMW);
  localparam int WIW = $clog2(MEMW + 1);
  localparam int LIM = MEMW * 4;
  localparam int CMX = (ACT_LAT > TEAR_LAT) ? ACT_LAT : TEAR_LAT;
  localparam int CNW = $clog2(CMX + 1);
  localparam logic [2:0] A_STAT = 3'd0, A_SMASK = 3'd1, A_IMASK = 3'd2,
                         A_EVT = 3'd3, A_XFER = 3'd4, A_SIZE = 3'd5;

  typedef enum logic [1:0] {IDLE, ARM, RUN, TEAR} phase_t;

  phase_t           phase;
  logic [CNW-1:0]   cnt;
  logic [NSOCK-1:0] stat, smask, clr;
  logic [3:0]       imask, event_v;
  logic             err, dir, lng;
  logic [SKW-1:0]   sel;
  logic [SZW-1:0]   size_q, cap;
  logic [WIW-1:0]   wcnt, last_q;
  logic [WM_LAG-1:0] wm_sr;
  logic [DW-1:0]    mem [MEMW];

  logic rdy, running, ok_wr, ok_rd, acc_ok, bad, wvalid, last, wm_hit, accept, wmark;

  function automatic logic [WIW-1:0] last_idx(input logic [SZW-1:0] b);
    int w;
    w = (int'(b) + 3) / 4;
    if (w == 0) w = 1;
    return WIW'(((w + BURST - 1) / BURST) * BURST - 1);
  endfunction

  assign cap     = (int'(buf_bytes) > LIM) ? SZW'(LIM) : buf_bytes;
  assign running = (phase == RUN);
  assign rdy     = (phase == RUN) || (phase == TEAR);
  assign ok_wr   = running && !dir;
  assign ok_rd   = running && dir;
  assign acc_ok  = (dat_wr && ok_wr) || (dat_rd && ok_rd);
  assign bad     = (dat_wr && !ok_wr) || (dat_rd && !ok_rd);
  assign wvalid  = (int'(wcnt) * 4) < int'(size_q);
  assign last    = acc_ok && (wcnt == last_q);
  assign wm_hit  = acc_ok && (wcnt == last_q - WIW'(BURST - 1 - WMARK));
  assign accept  = reg_wr && (reg_addr == A_XFER) && reg_wdata[9] && (phase == IDLE) && !err;
  assign wmark   = rdy && !wm_sr[WM_LAG-1];
  assign clr     = (phase == TEAR && cnt == CNW'(TEAR_LAT - 1) && !bad) ? (NSOCK'(1) << sel) : '0;

  assign event_v   = {err, wmark, rdy, |(stat & smask)};
  assign intr      = |(event_v & imask);
  assign dat_rdata = (ok_rd && wvalid) ? mem[wcnt[MIW-1:0]] : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata[NSOCK-1:0] = stat;
      A_SMASK: reg_rdata[NSOCK-1:0] = smask;
      A_IMASK: reg_rdata[3:0] = imask;
      A_EVT:   reg_rdata[3:0] = event_v;
      A_XFER: begin
        reg_rdata[SKW-1:0] = sel;
        reg_rdata[8]  = dir;
        reg_rdata[9]  = rdy;
        reg_rdata[10] = lng;
        reg_rdata[11] = rdy;
      end
      A_SIZE:  if (rdy) reg_rdata[SZW-1:0] = size_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE; cnt <= '0; stat <= '0; smask <= '0; imask <= '0; err <= 1'b0;
      sel <= '0; dir <= 1'b0; lng <= 1'b0; size_q <= '0; last_q <= '0;
      wcnt <= '0; wm_sr <= '0;
    end else begin
      stat <= (stat & ~clr) | sock_fill;
      if (reg_wr && reg_addr == A_SMASK) smask <= reg_wdata[NSOCK-1:0];
      if (reg_wr && reg_addr == A_IMASK) imask <= reg_wdata[3:0];
      if (bad) err <= 1'b1;
      else if (reg_wr && reg_addr == A_EVT && reg_wdata[3]) err <= 1'b0;
      if (acc_ok) wcnt <= wcnt + 1'b1;
      wm_sr[0] <= wm_sr[0] | wm_hit;
      for (int i = 1; i < WM_LAG; i++) wm_sr[i] <= wm_sr[i-1];
      case (phase)
        IDLE: if (accept) begin
          phase  <= ARM;
          cnt    <= '0;
          sel    <= reg_wdata[SKW-1:0];
          dir    <= reg_wdata[8];
          lng    <= reg_wdata[10];
          size_q <= cap;
          last_q <= last_idx(cap);
          wcnt   <= '0;
          wm_sr  <= '0;
        end
        ARM:
          if (bad) phase <= IDLE;
          else if (cnt == CNW'(ACT_LAT - 1)) phase <= RUN;
          else cnt <= cnt + 1'b1;
        RUN:
          if (bad) phase <= IDLE;
          else if (last) begin phase <= TEAR; cnt <= '0; end
        TEAR:
          if (bad || cnt == CNW'(TEAR_LAT - 1)) phase <= IDLE;
          else cnt <= cnt + 1'b1;
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= '0;
    end else if (dat_wr && ok_wr && wvalid) begin
      mem[wcnt[MIW-1:0]] <= dat_wdata;
    end
  end
endmodule

// File: rtl/sockdma_port_chk.sv
`timescale 1ns/1ps
module sockdma_port_chk #(
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          rdy,
  input logic          err,
  input logic          dat_wr,
  input logic          dat_rd,
  input logic [DW-1:0] dat_rdata,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata
);
  p_err_blocks_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rdy);

  p_stray_write_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !rdy) |=> err);

  p_closed_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !rdy) |-> dat_rdata == '0);

  p_err_host_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(reg_wr && reg_addr == 3'd3 && reg_wdata[3]));
endmodule

bind sockdma_port sockdma_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .err(err), .dat_wr(dat_wr), .dat_rd(dat_rd),
  .dat_rdata(dat_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_sockdma_port.sv
`timescale 1ns/1ps
module sim_sockdma_port;
  localparam int TEAR = 2;
  localparam int ACT  = 3;
  localparam logic [2:0] A_STAT = 0, A_SMASK = 1, A_IMASK = 2, A_EVT = 3, A_XFER = 4, A_SIZE = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] sock_fill = '0;
  logic [7:0] buf_bytes = '0;
  logic reg_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, dat_wdata = '0, dat_rdata;
  logic intr;
  int nchk = 0, nerr = 0;
  logic [31:0] bmem [16];

  always #10 clk = ~clk;

  sockdma_port u0 (.clk, .rst_n, .sock_fill, .buf_bytes, .reg_wr, .reg_addr, .reg_wdata,
                   .reg_rdata, .dat_wr, .dat_rd, .dat_wdata, .dat_rdata, .intr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int total_words(input int bytes);
    int w;
    if (bytes > 64) bytes = 64;
    w = (bytes + 3) / 4;
    if (w == 0) w = 1;
    return ((w + 3) / 4) * 4;
  endfunction

  task automatic rwr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic dacc(input logic w, input logic r, input logic [31:0] wd, output logic [31:0] rd);
    dat_wr = w; dat_rd = r; dat_wdata = wd; #2; rd = dat_rdata;
    @(posedge clk); @(negedge clk);
    dat_wr = 1'b0; dat_rd = 1'b0;
  endtask

  task automatic arm(input int sock, input logic dir, input logic lng, input logic [7:0] bytes);
    buf_bytes = bytes;
    rwr(A_XFER, 32'(sock) | (32'(dir) << 8) | 32'h200 | (32'(lng) << 10));
  endtask

  task automatic xfer(input int sock, input logic dir, input int bytes);
    logic [31:0] v, rd, wd;
    int tot, sz;
    sz = (bytes > 64) ? 64 : bytes;
    tot = total_words(bytes);
    arm(sock, dir, 1'b0, 8'(bytes));
    repeat (ACT) @(negedge clk);
    rrd(A_XFER, v); chk("R3 enable after arming", 32'(v[9]), 1);
    rrd(A_SIZE, v); chk("R3 size", v, 32'(sz));
    for (int i = 0; i < tot; i++) begin
      rrd(A_EVT, v); chk("R5 ready inside window", 32'(v[1]), 1);
      wd = $urandom;
      dacc(!dir, dir, wd, rd);
      if (dir) chk("R6 egress word", rd, (i * 4 < sz) ? bmem[i] : 32'h0);
      else if (i * 4 < sz) bmem[i] = wd;
    end
    for (int t = 0; t < TEAR - 1; t++) begin
      rrd(A_XFER, v); chk("R8 enable held in teardown", 32'(v[9]), 1);
      @(negedge clk);
    end
    rrd(A_XFER, v); chk("R8 enable held in teardown", 32'(v[9]), 1);
    @(negedge clk);
    rrd(A_XFER, v); chk("R8 enable cleared", 32'(v[9]), 0);
    rrd(A_STAT, v); chk("R8 status cleared", 32'(v[sock]), 0);
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v, rd;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rrd(3'(a), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset intr", 32'(intr), 0);
    chk("R1 reset rdata", dat_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    sock_fill = 4'b0100; @(posedge clk); @(negedge clk); sock_fill = '0;
    rrd(A_STAT, v); chk("R2 status set", v, 32'h4);
    rrd(A_EVT, v); chk("R2 masked out", 32'(v[0]), 0);
    chk("R2 no intr", 32'(intr), 0);
    rwr(A_SMASK, 32'h4); rwr(A_IMASK, 32'h1);
    rrd(A_EVT, v); chk("R2 masked in", 32'(v[0]), 1);
    chk("R2 intr raised", 32'(intr), 1);
    rwr(A_IMASK, 32'h2);
    chk("R2 intr gated", 32'(intr), 0);

    arm(2, 1'b0, 1'b1, 8'd32);
    for (int c = 0; c < ACT; c++) begin
      rrd(A_XFER, v); chk("R3 enable not yet", 32'(v[9]), 0);
      rrd(A_SIZE, v); chk("R3 size hidden", v, 0);
      @(negedge clk);
    end
    rrd(A_XFER, v);
    chk("R3 enable", 32'(v[9]), 1);
    chk("R3 size valid", 32'(v[11]), 1);
    chk("R3 socket field", 32'(v[3:0]), 2);
    chk("R3 direction", 32'(v[8]), 0);
    chk("R4 long flag", 32'(v[10]), 1);
    rrd(A_EVT, v); chk("R3 ready", 32'(v[1]), 1);
    chk("R2 intr on ready", 32'(intr), 1);
    rrd(A_SIZE, v); chk("R3 size value", v, 32);
    rwr(A_XFER, 32'h201);
    rrd(A_XFER, v); chk("R11 rearm ignored", 32'(v[3:0]), 2);
    for (int i = 0; i < 7; i++) begin
      rrd(A_EVT, v); chk("R7 watermark before", 32'(v[2]), 1);
      bmem[i] = 32'hA000_0000 + 32'(i);
      dacc(1'b1, 1'b0, bmem[i], rd);
    end
    rrd(A_EVT, v); chk("R7 watermark lag", 32'(v[2]), 1);
    @(negedge clk);
    rrd(A_EVT, v); chk("R7 watermark dropped", 32'(v[2]), 0);
    bmem[7] = 32'hA000_0007;
    dacc(1'b1, 1'b0, bmem[7], rd);
    rrd(A_XFER, v); chk("R8 enable held", 32'(v[9]), 1);
    @(negedge clk);
    rrd(A_XFER, v); chk("R8 enable held", 32'(v[9]), 1);
    @(negedge clk);
    rrd(A_XFER, v); chk("R8 enable off", 32'(v[9]), 0);
    rrd(A_EVT, v); chk("R8 ready off", 32'(v[1]), 0);
    rrd(A_STAT, v); chk("R8 status bit off", v, 0);

    arm(0, 1'b0, 1'b0, 8'd8);
    repeat (ACT) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rrd(A_XFER, v); chk("R5 still enabled", 32'(v[9]), 1);
      dacc(1'b1, 1'b0, 32'hB000_0000 + 32'(i), rd);
      if (i < 2) bmem[i] = 32'hB000_0000 + 32'(i);
    end
    repeat (TEAR) @(negedge clk);
    rrd(A_XFER, v); chk("R5 done after one burst", 32'(v[9]), 0);
    xfer(1, 1'b1, 32);
    xfer(3, 1'b1, 5);
    xfer(0, 1'b1, 100);

    dacc(1'b1, 1'b0, 32'hDEAD_BEEF, rd);
    rrd(A_EVT, v); chk("R9 idle write errors", 32'(v[3]), 1);
    dacc(1'b0, 1'b1, 0, rd);
    chk("R9 idle read zero", rd, 0);
    rwr(A_IMASK, 32'h8);
    chk("R9 error interrupt", 32'(intr), 1);
    arm(1, 1'b1, 1'b0, 8'd16);
    repeat (ACT + 1) @(negedge clk);
    rrd(A_XFER, v); chk("R10 arming refused", 32'(v[9]), 0);
    rwr(A_EVT, 32'h0);
    rrd(A_EVT, v); chk("R10 sticky error", 32'(v[3]), 1);
    rwr(A_EVT, 32'h8);
    rrd(A_EVT, v); chk("R10 error cleared", 32'(v[3]), 0);
    xfer(2, 1'b1, 16);

    arm(1, 1'b0, 1'b0, 8'd16);
    repeat (ACT) @(negedge clk);
    dacc(1'b0, 1'b1, 0, rd);
    chk("R9 wrong direction read zero", rd, 0);
    rrd(A_XFER, v); chk("R9 abort enable", 32'(v[9]), 0);
    rrd(A_EVT, v); chk("R9 abort ready", 32'(v[1]), 0);
    chk("R9 abort error", 32'(v[3]), 1);
    rwr(A_EVT, 32'h8);

    arm(0, 1'b0, 1'b0, 8'd4);
    repeat (ACT) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      dacc(1'b1, 1'b0, 32'hC000_0000, rd);
      if (i == 0) bmem[0] = 32'hC000_0000;
    end
    dacc(1'b1, 1'b0, 32'h1234_5678, rd);
    rrd(A_EVT, v); chk("R8 after-last access errors", 32'(v[3]), 1);
    rwr(A_EVT, 32'h8);
    xfer(0, 1'b1, 16);

    for (int n = 0; n < 24; n++) begin
      xfer(int'($urandom_range(0, 3)), 1'(n % 2), int'($urandom_range(1, 70)));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule